// File: doc/BRIEF.md
# Line-Buffered Bayer Demosaic Bridge

This block takes raw 10-bit Bayer samples from a camera running on its own pixel clock and turns them into 8-bit-per-colour RGB pixels for a display timing generator running on an unrelated pixel clock. Both sides carry a 640x480 active image at the same frame rate. The small frequency offset between the two clocks is absorbed by three line memories, so no frame buffer is needed.

Capture writes each incoming line into one of three line memories in turn. The display side reads the two memories that hold one vertically adjacent line pair. The colour filter is assumed to repeat as a 2x2 cell with red top-left, green top-right, green bottom-left and blue bottom-right. Each output pixel takes the cell whose top-left corner sits at the even row and even column at or just above and left of it. The cell therefore covers a 2x2 block of output pixels.

The capture side reports how many lines of the current frame are complete. That count reaches the display clock domain as a Gray code through a two-flop synchroniser. A row is emitted only once both of its source lines are complete. Otherwise, and outside the display's active region, the output is black.

Top module: `raw2rgb_linebuf`

## Requirements
- R1: Capture line k of a frame (counting from 0 after the frame-start pulse) is written to line memory k mod 3. The write memory index therefore advances 0, 1, 2, 0 on each falling edge of the line-valid input, and it returns to 0 on the frame-start pulse.
- R2: The completed-line count clears to 0 on the frame-start pulse. It rises by exactly one on each falling edge of line-valid and saturates at the number of active rows. At any other time it holds its value.
- R3: The completed-line count crosses to the display domain as a Gray code, which changes in at most one bit between successive capture clock edges except right after a frame start.
- R4: Output red is the top 8 bits of the raw sample at row 2*floor(y/2), column 2*floor(x/2).
- R5: Output green is bits 10..3 of the sum of two samples: the one at the cell's top row, odd column, and the one at its bottom row, even column.
- R6: Output blue is the top 8 bits of the raw sample at row 2*floor(y/2)+1, column 2*floor(x/2)+1.
- R7: The RGB value for the coordinates presented with display-enable appears two display clock cycles later.
- R8: When display-enable was low two display cycles earlier, the output is black (all three channels 0). The output is also black from reset.
- R9: Display row y is black until lines 2*floor(y/2) and 2*floor(y/2)+1 of the current frame are both complete. A frame-start pulse makes every row black again until its lines arrive anew.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk | input | 1 | Camera pixel clock |
| cap_rst_n | input | 1 | Active-low synchronous reset, capture domain |
| cap_vsync | input | 1 | Frame-start pulse, one capture cycle, while line-valid is low |
| cap_hsync | input | 1 | Line-valid, high for each active pixel of a line |
| cap_pix | input | DW (10) | Raw Bayer sample |
| dsp_clk | input | 1 | Display pixel clock |
| dsp_rst_n | input | 1 | Active-low synchronous reset, display domain |
| dsp_de | input | 1 | Display active-region enable |
| dsp_x | input | clog2(H_ACT) | Display column of the current pixel |
| dsp_y | input | clog2(V_ACT) | Display row of the current pixel |
| rgb_r | output | OW (8) | Red output |
| rgb_g | output | OW (8) | Green output |
| rgb_b | output | OW (8) | Blue output |

## Verification
The assertions watch the capture-side bookkeeping on every cycle: the write memory rotation and its reset on frame start, the line count stepping by one or holding, and the Gray code changing in at most one bit. On the display side they check that a low display-enable always gives black two cycles later. Colour reconstruction, the two-cycle alignment of data with coordinates, and the black output while the source lines are incomplete all depend on pixel values and on the hand-off across clock domains. Only the bench scenarios show these: whole frames of known patterns, swept over every column of every row pair, with expected values worked out from the sample formula.

// File: rtl/lb_pkg.sv
// Shared types and helpers for the line-buffered demosaic bridge.
// Assumes exactly three line memories used in rotation.
package lb_pkg;
    localparam int N_BANKS = 3;
    typedef logic [1:0] bank_t;

    // Next line memory in the rotation 0 -> 1 -> 2 -> 0.
    function automatic bank_t next_bank(input bank_t b);
        return (b == bank_t'(N_BANKS - 1)) ? bank_t'(0) : b + bank_t'(1);
    endfunction
endpackage

// File: rtl/lb_line_store.sv
// Three dual-clock line memories, each holding one line as pixel pairs.
// Word layout: lower DW bits = even column, upper DW bits = odd column.
// Assumes H is even. All banks are read at one shared address.
module lb_line_store
    import lb_pkg::*;
#(
    parameter int DW  = 10,
    parameter int H   = 640,
    localparam int WW  = 2 * DW,
    localparam int DEP = H / 2,
    localparam int A_W = $clog2(DEP)
) (
    input  logic                   wclk,
    input  logic                   we,
    input  bank_t                  wbank,
    input  logic [A_W-1:0]         waddr,
    input  logic [WW-1:0]          wdata,
    input  logic                   rclk,
    input  logic [A_W-1:0]         raddr,
    output logic [N_BANKS*WW-1:0]  rdata_all
);
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [WW-1:0] mem [DEP];

        // Write port: store one pixel pair when this bank is selected.
        always_ff @(posedge wclk) begin
            if (we && wbank == bank_t'(b))
                mem[waddr] <= wdata;
        end

        // Read port: registered read on the display clock.
        always_ff @(posedge rclk) begin
            rdata_all[b*WW +: WW] <= mem[raddr];
        end
    end
endmodule

// File: rtl/lb_capture_ctrl.sv
// Capture-side control: pairs pixels, rotates the write bank at each
// line end, counts completed lines per frame and Gray-codes that count.
// Assumes frame start arrives while line-valid is low.
module lb_capture_ctrl
    import lb_pkg::*;
#(
    parameter int DW = 10,
    parameter int H  = 640,
    parameter int V  = 480,
    localparam int X_W   = $clog2(H),
    localparam int A_W   = $clog2(H / 2),
    localparam int CNT_W = $clog2(V + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync,
    input  logic               hsync,
    input  logic [DW-1:0]      pix,
    output logic               we,
    output bank_t              wbank,
    output logic [A_W-1:0]     waddr,
    output logic [2*DW-1:0]    wdata,
    output logic [CNT_W-1:0]   lines,
    output logic [CNT_W-1:0]   gray
);
    logic [X_W-1:0] col;
    logic [DW-1:0]  even_q;
    logic           hs_q;

    // Column, pairing, bank rotation, line count and Gray encoding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q   <= 1'b0;
            col    <= '0;
            even_q <= '0;
            wbank  <= bank_t'(0);
            lines  <= '0;
            gray   <= '0;
        end else begin
            hs_q <= hsync;
            if (vsync) begin
                col   <= '0;
                wbank <= bank_t'(0);
                lines <= '0;
            end else begin
                if (hsync) begin
                    col <= col + 1'b1;
                    if (!col[0])
                        even_q <= pix;
                end
                if (hs_q && !hsync) begin
                    col   <= '0;
                    wbank <= next_bank(wbank);
                    if (lines != CNT_W'(V))
                        lines <= lines + 1'b1;
                end
            end
            gray <= lines ^ (lines >> 1);
        end
    end

    // Write on the odd pixel of each pair, carrying the held even one.
    assign we    = hsync && col[0] && !vsync;
    assign waddr = A_W'(col >> 1);
    assign wdata = {pix, even_q};
endmodule

// File: rtl/lb_gray_sync.sv
// Two-flop synchroniser for a Gray-coded count, decoded to binary.
// Assumes the source changes at most one bit per source clock.
module lb_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1, s2;

    // Two flop stages into the display clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    // Gray to binary: each bit is the parity of all bits at or above it.
    for (genvar i = 0; i < W; i++) begin : g_dec
        assign bin_out[i] = ^(s2 >> i);
    end
endmodule

// File: rtl/lb_demosaic.sv
// Display-side pipeline: picks the two banks of the needed line pair,
// gates on line availability and display enable, rebuilds R, G, B.
// Two display cycles from coordinates to registered colour.
module lb_demosaic
    import lb_pkg::*;
#(
    parameter int DW = 10,
    parameter int OW = 8,
    parameter int H  = 640,
    parameter int V  = 480,
    localparam int X_W   = $clog2(H),
    localparam int Y_W   = $clog2(V),
    localparam int A_W   = $clog2(H / 2),
    localparam int WW    = 2 * DW,
    localparam int CNT_W = $clog2(V + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  de,
    input  logic [X_W-1:0]        x,
    input  logic [Y_W-1:0]        y,
    input  logic [CNT_W-1:0]      lines_avail,
    output logic [A_W-1:0]        rd_addr,
    input  logic [N_BANKS*WW-1:0] rd_all,
    output logic [OW-1:0]         r,
    output logic [OW-1:0]         g,
    output logic [OW-1:0]         b
);
    logic [Y_W-1:0] ty;
    bank_t          top_c, top_q, bot_q;
    logic           ready, val_q;
    logic [WW-1:0]  top_w, bot_w;
    logic [DW:0]    gsum;

    assign ty      = y & ~Y_W'(1);
    assign ready   = int'(lines_avail) >= int'(ty) + 2;
    assign top_c   = bank_t'(ty % Y_W'(N_BANKS));
    assign rd_addr = A_W'(x >> 1);

    // Stage 1: remember bank choice and validity beside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= 1'b0;
            top_q <= bank_t'(0);
            bot_q <= bank_t'(0);
        end else begin
            val_q <= de && ready;
            top_q <= top_c;
            bot_q <= next_bank(top_c);
        end
    end

    assign top_w = rd_all[int'(top_q)*WW +: WW];
    assign bot_w = rd_all[int'(bot_q)*WW +: WW];
    assign gsum  = {1'b0, top_w[WW-1:DW]} + {1'b0, bot_w[DW-1:0]};

    // Stage 2: build colour from the cell, or black when not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r <= '0;
            g <= '0;
            b <= '0;
        end else if (val_q) begin
            r <= top_w[DW-1 -: OW];
            g <= gsum[DW -: OW];
            b <= bot_w[WW-1 -: OW];
        end else begin
            r <= '0;
            g <= '0;
            b <= '0;
        end
    end
endmodule

// File: rtl/raw2rgb_linebuf.sv
// Top: raw Bayer capture into three rotating line memories, RGB out on
// the display clock. Assumes equal frame rates on both sides.
module raw2rgb_linebuf
    import lb_pkg::*;
#(
    parameter int DW = 10,
    parameter int OW = 8,
    parameter int H_ACT = 640,
    parameter int V_ACT = 480,
    localparam int X_W   = $clog2(H_ACT),
    localparam int Y_W   = $clog2(V_ACT),
    localparam int A_W   = $clog2(H_ACT / 2),
    localparam int WW    = 2 * DW,
    localparam int CNT_W = $clog2(V_ACT + 1)
) (
    input  logic           cap_clk,
    input  logic           cap_rst_n,
    input  logic           cap_vsync,
    input  logic           cap_hsync,
    input  logic [DW-1:0]  cap_pix,
    input  logic           dsp_clk,
    input  logic           dsp_rst_n,
    input  logic           dsp_de,
    input  logic [X_W-1:0] dsp_x,
    input  logic [Y_W-1:0] dsp_y,
    output logic [OW-1:0]  rgb_r,
    output logic [OW-1:0]  rgb_g,
    output logic [OW-1:0]  rgb_b
);
    logic                  wr_en;
    bank_t                 wr_bank;
    logic [A_W-1:0]        wr_addr, rd_addr;
    logic [WW-1:0]         wr_data;
    logic [CNT_W-1:0]      line_cnt, line_gray, line_avail;
    logic [N_BANKS*WW-1:0] rd_all;

    lb_capture_ctrl #(.DW(DW), .H(H_ACT), .V(V_ACT)) u_cap (
        .clk(cap_clk), .rst_n(cap_rst_n), .vsync(cap_vsync),
        .hsync(cap_hsync), .pix(cap_pix), .we(wr_en), .wbank(wr_bank),
        .waddr(wr_addr), .wdata(wr_data), .lines(line_cnt), .gray(line_gray)
    );

    lb_line_store #(.DW(DW), .H(H_ACT)) u_store (
        .wclk(cap_clk), .we(wr_en), .wbank(wr_bank), .waddr(wr_addr),
        .wdata(wr_data), .rclk(dsp_clk), .raddr(rd_addr), .rdata_all(rd_all)
    );

    lb_gray_sync #(.W(CNT_W)) u_sync (
        .clk(dsp_clk), .rst_n(dsp_rst_n), .gray_in(line_gray),
        .bin_out(line_avail)
    );

    lb_demosaic #(.DW(DW), .OW(OW), .H(H_ACT), .V(V_ACT)) u_dm (
        .clk(dsp_clk), .rst_n(dsp_rst_n), .de(dsp_de), .x(dsp_x),
        .y(dsp_y), .lines_avail(line_avail), .rd_addr(rd_addr),
        .rd_all(rd_all), .r(rgb_r), .g(rgb_g), .b(rgb_b)
    );
endmodule

// File: rtl/lb_checker.sv
// Property checker for raw2rgb_linebuf, bound into every instance.
// Watches capture bookkeeping and display-side blanking.
module lb_checker
    import lb_pkg::*;
#(
    parameter int V     = 480,
    parameter int CNT_W = 9,
    parameter int OW    = 8
) (
    input logic             cap_clk,
    input logic             cap_rst_n,
    input logic             cap_vsync,
    input logic             cap_hsync,
    input bank_t            wr_bank,
    input logic [CNT_W-1:0] line_cnt,
    input logic [CNT_W-1:0] line_gray,
    input logic             dsp_clk,
    input logic             dsp_rst_n,
    input logic             dsp_de,
    input logic [OW-1:0]    rgb_r,
    input logic [OW-1:0]    rgb_g,
    input logic [OW-1:0]    rgb_b
);
    logic [1:0] cap_age, dsp_age;

    // Cycles since capture reset, saturating, to gate $past lookups.
    always_ff @(posedge cap_clk) begin
        if (!cap_rst_n)          cap_age <= '0;
        else if (cap_age != 2'd3) cap_age <= cap_age + 1'b1;
    end

    // Cycles since display reset, saturating.
    always_ff @(posedge dsp_clk) begin
        if (!dsp_rst_n)          dsp_age <= '0;
        else if (dsp_age != 2'd3) dsp_age <= dsp_age + 1'b1;
    end

    assert_bank_range_R1: assert property (@(posedge cap_clk)
        disable iff (!cap_rst_n) wr_bank != bank_t'(3));

    assert_bank_rotate_R1: assert property (@(posedge cap_clk)
        disable iff (!cap_rst_n || cap_age == 2'd0)
        ($fell(cap_hsync) && !cap_vsync) |=> wr_bank == next_bank($past(wr_bank)));

    assert_frame_clear_R1: assert property (@(posedge cap_clk)
        disable iff (!cap_rst_n) cap_vsync |=> (wr_bank == bank_t'(0) && line_cnt == '0));

    assert_count_step_R2: assert property (@(posedge cap_clk)
        disable iff (!cap_rst_n || cap_age == 2'd0)
        ($fell(cap_hsync) && !cap_vsync) |=>
            (int'(line_cnt) == ((int'($past(line_cnt)) == V) ? V : int'($past(line_cnt)) + 1)));

    assert_count_hold_R2: assert property (@(posedge cap_clk)
        disable iff (!cap_rst_n || cap_age == 2'd0)
        (!$fell(cap_hsync) && !cap_vsync) |=> $stable(line_cnt));

    assert_gray_onebit_R3: assert property (@(posedge cap_clk)
        disable iff (!cap_rst_n || cap_age < 2'd2)
        (!$past(cap_vsync) && !$past(cap_vsync, 2)) |->
            $countones(line_gray ^ $past(line_gray)) <= 1);

    assert_blank_black_R8: assert property (@(posedge dsp_clk)
        disable iff (!dsp_rst_n || dsp_age < 2'd2)
        !$past(dsp_de, 2) |-> (rgb_r == '0 && rgb_g == '0 && rgb_b == '0));
endmodule

bind raw2rgb_linebuf lb_checker #(.V(V_ACT), .CNT_W(CNT_W), .OW(OW)) u_chk (
    .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .cap_vsync(cap_vsync),
    .cap_hsync(cap_hsync), .wr_bank(wr_bank), .line_cnt(line_cnt),
    .line_gray(line_gray), .dsp_clk(dsp_clk), .dsp_rst_n(dsp_rst_n),
    .dsp_de(dsp_de), .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
);

// File: tb/raw2rgb_linebuf_bench.sv
// Bench: small 8x6 image, two frames with different sample patterns,
// every pixel of every row pair swept and compared against the formula.
module raw2rgb_linebuf_bench;
    localparam int H = 8;
    localparam int V = 6;
    localparam int X_W = $clog2(H);
    localparam int Y_W = $clog2(V);

    logic cap_clk = 1'b0, dsp_clk = 1'b0;
    logic cap_rst_n = 1'b0, dsp_rst_n = 1'b0;
    logic cap_vsync = 1'b0, cap_hsync = 1'b0;
    logic [9:0] cap_pix = '0;
    logic dsp_de = 1'b0;
    logic [X_W-1:0] dsp_x = '0;
    logic [Y_W-1:0] dsp_y = '0;
    logic [7:0] rgb_r, rgb_g, rgb_b;

    int n_chk = 0;
    int n_fail = 0;

    always #5   dsp_clk = ~dsp_clk;
    always #6.5 cap_clk = ~cap_clk;

    raw2rgb_linebuf #(.DW(10), .OW(8), .H_ACT(H), .V_ACT(V)) u_raw2rgb_linebuf (
        .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .cap_vsync(cap_vsync),
        .cap_hsync(cap_hsync), .cap_pix(cap_pix), .dsp_clk(dsp_clk),
        .dsp_rst_n(dsp_rst_n), .dsp_de(dsp_de), .dsp_x(dsp_x), .dsp_y(dsp_y),
        .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
    );

    function automatic int sample(input int f, input int row, input int c);
        return (row * 97 + c * 53 + f * 211 + 5) & 1023;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic cap_frame_start;
        @(negedge cap_clk) cap_vsync = 1'b1;
        @(negedge cap_clk) cap_vsync = 1'b0;
        repeat (2) @(negedge cap_clk);
    endtask

    task automatic cap_line(input int f, input int row);
        for (int c = 0; c < H; c++) begin
            @(negedge cap_clk);
            cap_hsync = 1'b1;
            cap_pix   = 10'(sample(f, row, c));
        end
        @(negedge cap_clk) cap_hsync = 1'b0;
        repeat (3) @(negedge cap_clk);
    endtask

    task automatic settle;
        repeat (8) @(negedge dsp_clk);
    endtask

    // Sweep one display row; output for column i is read two cycles later (R7).
    task automatic show_row(input int f, input int y, input bit de_on,
                            input bit want_black, input string req);
        for (int i = 0; i < H + 2; i++) begin
            @(negedge dsp_clk);
            if (i >= 2) begin
                int px, ty, tx, er, eg, eb;
                px = i - 2;
                ty = y & ~1;
                tx = px & ~1;
                er = sample(f, ty, tx) >> 2;
                eg = (sample(f, ty, tx + 1) + sample(f, ty + 1, tx)) >> 3;
                eb = sample(f, ty + 1, tx + 1) >> 2;
                if (want_black || !de_on) begin
                    er = 0; eg = 0; eb = 0;
                end
                check(req, {rgb_r, rgb_g, rgb_b}, (er << 16) | (eg << 8) | eb);
            end
            if (i < H) begin
                dsp_de = de_on;
                dsp_x  = X_W'(i);
                dsp_y  = Y_W'(y);
            end else begin
                dsp_de = 1'b0;
            end
        end
    endtask

    task automatic run_frame(input int f);
        cap_frame_start();
        settle();
        show_row(f, 4, 1'b1, 1'b1, "R9 row black after frame start");
        cap_line(f, 0);
        settle();
        show_row(f, 0, 1'b1, 1'b1, "R9 row black with one line stored");
        for (int p = 0; p < V; p += 2) begin
            if (p != 0) cap_line(f, p);
            cap_line(f, p + 1);
            settle();
            // R4 R5 R6 colour of both rows of the pair; R1 bank rotation.
            show_row(f, p,     1'b1, 1'b0, "R4/R5/R6 R1 even row");
            show_row(f, p + 1, 1'b1, 1'b0, "R4/R5/R6 R7 odd row");
            show_row(f, p + 1, 1'b0, 1'b0, "R8 enable low black");
        end
        // R2: an extra line past the last row saturates the count; rows 4,5 stay ready.
        cap_line(f, V);
        settle();
        show_row(f, V - 1, 1'b1, 1'b0, "R2 saturated count keeps rows ready");
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge cap_clk);
        repeat (2) @(negedge dsp_clk);
        cap_rst_n = 1'b1;
        dsp_rst_n = 1'b1;
        @(negedge dsp_clk);
        check("R8 reset black", {rgb_r, rgb_g, rgb_b}, 0);
        run_frame(0);
        run_frame(1);
        summary();
        $finish;
    end
endmodule